// File: doc/BRIEF.md
# Time-Multiplexed Quadrature Mixer

This block translates a real sampled signal down to baseband. Each accepted input sample is multiplied by the cosine value of a carrier pair to form the in-phase (I) product, and by the sine value to form the quadrature (Q) product. All three inputs are 16-bit signed fixed point with 15 fractional bits. The carrier pair comes from an external numerically controlled oscillator and is sampled together with the input sample.

Only one multiplier is built. A small sequencer state machine feeds it the cosine operand in the first cycle and the sine operand in the second. Because of this, the block accepts at most one sample every two clocks. The sequencer has two states. In `SEQ_OPEN` the ready output is high, and an accepted sample moves it to `SEQ_SECOND`. In `SEQ_SECOND` the ready output is low, the stored sine operand is issued, and the state always returns to `SEQ_OPEN`. The pipeline has a register before the multiplier, a register after it, and a register after rounding, so every stage is short enough for a clock of about 200 MHz. The I result is parked until its Q partner is ready. Both are then presented together with a one-cycle valid pulse.

Top module: `tdm_quad_mixer`

## Requirements
- R1: While reset is asserted and directly after it, out_valid is 0, out_i and out_q are 0, and in_ready is 1.
- R2: A sample is accepted on a rising edge where in_valid and in_ready are both 1. In the cycle after an acceptance, in_ready is 0. One cycle later it is 1 again.
- R3: Each accepted sample produces exactly one out_valid pulse, one cycle wide, on the 4th rising edge after the acceptance edge. No pulse appears without an accepted sample.
- R4: out_i equals sample × cosine reduced to 16 bits.
- R5: out_q equals sample × sine reduced to 16 bits, and it is presented in the same cycle as its out_i.
- R6: The reduction of the 32-bit product p is floor((p + 2^14) / 2^15), that is, round half up. For example, 16384 × 1 gives 1 and 16384 × −1 gives 0.
- R7: A reduced value above +32767 saturates to +32767. The only such case is −32768 × −32768, on either carrier.
- R8: Samples offered back to back are accepted every second clock, and each result stays paired with its own sample.
- R9: Any sample or carrier presented while in_ready is 0 is ignored. It does not alter the result of the sample in flight and produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample and carrier pair are valid |
| in_ready | output | 1 | Block can accept an input this cycle |
| in_sample | input | 16 | Signed input sample, Q1.15 |
| in_cos | input | 16 | Signed cosine carrier, Q1.15 |
| in_sin | input | 16 | Signed sine carrier, Q1.15 |
| out_valid | output | 1 | One-cycle pulse: out_i and out_q are valid |
| out_i | output | 16 | Rounded, saturated in-phase product |
| out_q | output | 16 | Rounded, saturated quadrature product |

## Verification
At full throughput, two events share one rising edge. The output pulse of one sample lands on the same edge where a later sample is accepted. The pair assembler also parks the I result of one sample only one edge after it presented the Q result of the previous sample. The sweep provokes both by offering samples back to back on every other row of the sample × carrier grid. The remaining rows leave idle gaps between samples. Each pulse is judged against the cycle number and the arithmetic result recorded for its own accepted sample. A stale I pairing or a carrier taken from a later sample therefore shows up as a value mismatch.

// File: rtl/qmix_pkg.sv
package qmix_pkg;

    typedef enum logic {
        SEQ_OPEN   = 1'b0,
        SEQ_SECOND = 1'b1
    } seq_state_e;

    typedef enum logic {
        LEG_COS = 1'b0,
        LEG_SIN = 1'b1
    } leg_e;

    typedef struct packed {
        logic vld;
        leg_e leg;
    } lane_tag_t;

endpackage

// File: rtl/mix_sequencer.sv
module mix_sequencer
    import qmix_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_sample,
    input  logic signed [DW-1:0] in_cos,
    input  logic signed [DW-1:0] in_sin,
    output logic                 in_ready,
    output logic signed [DW-1:0] op_a,
    output logic signed [DW-1:0] op_b,
    output lane_tag_t            op_tag
);
    seq_state_e          state_q, state_d;
    logic signed [DW-1:0] sin_keep;
    logic                 accept;

    assign in_ready = (state_q == SEQ_OPEN);
    assign accept   = in_valid && in_ready;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_OPEN:   state_d = accept ? SEQ_SECOND : SEQ_OPEN;
            SEQ_SECOND: state_d = SEQ_OPEN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_OPEN;
        else        state_q <= state_d;
    end

    // operand registers in front of the multiplier
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_a     <= '0;
            op_b     <= '0;
            sin_keep <= '0;
            op_tag   <= '{vld: 1'b0, leg: LEG_COS};
        end else begin
            unique case (state_q)
                SEQ_OPEN: begin
                    if (accept) begin
                        op_a     <= in_sample;
                        op_b     <= in_cos;
                        sin_keep <= in_sin;
                        op_tag   <= '{vld: 1'b1, leg: LEG_COS};
                    end else begin
                        op_tag.vld <= 1'b0;
                    end
                end
                SEQ_SECOND: begin
                    op_b   <= sin_keep;
                    op_tag <= '{vld: 1'b1, leg: LEG_SIN};
                end
            endcase
        end
    end
endmodule

// File: rtl/mix_mult_stage.sv
module mix_mult_stage
    import qmix_pkg::*;
#(
    parameter int DW = 16,
    parameter int PW = 2 * DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] op_a,
    input  logic signed [DW-1:0] op_b,
    input  lane_tag_t            op_tag,
    output logic signed [PW-1:0] prod_q,
    output lane_tag_t            prod_tag
);
    logic signed [PW-1:0] prod_d;

    // the single shared multiplier
    assign prod_d = PW'(op_a * op_b);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_q   <= '0;
            prod_tag <= '{vld: 1'b0, leg: LEG_COS};
        end else begin
            prod_tag <= op_tag;
            if (op_tag.vld) prod_q <= prod_d;
        end
    end
endmodule

// File: rtl/mix_round_sat.sv
module mix_round_sat
    import qmix_pkg::*;
#(
    parameter int DW = 16,
    parameter int PW = 2 * DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [PW-1:0] prod,
    input  lane_tag_t            prod_tag,
    output logic signed [DW-1:0] rnd_q,
    output lane_tag_t            rnd_tag
);
    localparam int FRAC = DW - 1;
    localparam int EW   = PW + 1;
    localparam logic signed [EW-1:0] HALF = EW'(1) <<< (FRAC - 1);
    localparam logic signed [EW-1:0] MAXV = (EW'(1) <<< (DW - 1)) - EW'(1);
    localparam logic signed [EW-1:0] MINV = -(EW'(1) <<< (DW - 1));

    logic signed [EW-1:0] biased, shifted;
    logic signed [DW-1:0] rnd_d;

    always_comb begin
        biased  = {prod[PW-1], prod} + HALF;
        shifted = biased >>> FRAC;
        if (shifted > MAXV)      rnd_d = MAXV[DW-1:0];
        else if (shifted < MINV) rnd_d = MINV[DW-1:0];
        else                     rnd_d = shifted[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rnd_q   <= '0;
            rnd_tag <= '{vld: 1'b0, leg: LEG_COS};
        end else begin
            rnd_tag <= prod_tag;
            if (prod_tag.vld) rnd_q <= rnd_d;
        end
    end
endmodule

// File: rtl/mix_pair_assembler.sv
module mix_pair_assembler
    import qmix_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] rnd,
    input  lane_tag_t            rnd_tag,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_i,
    output logic signed [DW-1:0] out_q
);
    logic signed [DW-1:0] i_park;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_park    <= '0;
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= 1'b0;
            if (rnd_tag.vld) begin
                unique case (rnd_tag.leg)
                    LEG_COS: i_park <= rnd;
                    LEG_SIN: begin
                        out_i     <= i_park;
                        out_q     <= rnd;
                        out_valid <= 1'b1;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/tdm_quad_mixer.sv
module tdm_quad_mixer
    import qmix_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic signed [DW-1:0] in_sample,
    input  logic signed [DW-1:0] in_cos,
    input  logic signed [DW-1:0] in_sin,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_i,
    output logic signed [DW-1:0] out_q
);
    localparam int PW = 2 * DW;

    logic signed [DW-1:0] op_a, op_b, rnd;
    logic signed [PW-1:0] prod;
    lane_tag_t            op_tag, prod_tag, rnd_tag;

    mix_sequencer #(.DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_sample(in_sample), .in_cos(in_cos), .in_sin(in_sin),
        .in_ready(in_ready), .op_a(op_a), .op_b(op_b), .op_tag(op_tag)
    );

    mix_mult_stage #(.DW(DW), .PW(PW)) u_mul (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .op_tag(op_tag), .prod_q(prod), .prod_tag(prod_tag)
    );

    mix_round_sat #(.DW(DW), .PW(PW)) u_rnd (
        .clk(clk), .rst_n(rst_n), .prod(prod), .prod_tag(prod_tag),
        .rnd_q(rnd), .rnd_tag(rnd_tag)
    );

    mix_pair_assembler #(.DW(DW)) u_pair (
        .clk(clk), .rst_n(rst_n), .rnd(rnd), .rnd_tag(rnd_tag),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );
endmodule

// File: rtl/qmix_checker.sv
module qmix_checker #(
    parameter int DW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic signed [DW-1:0] in_sample,
    input logic                 out_valid,
    input logic signed [DW-1:0] out_i,
    input logic signed [DW-1:0] out_q
);
    logic [4:0] acc_sr, zero_sr;
    logic       acc;

    assign acc = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_sr  <= '0;
            zero_sr <= '0;
        end else begin
            acc_sr  <= {acc_sr[3:0], acc};
            zero_sr <= {zero_sr[3:0], acc && (in_sample == '0)};
        end
    end

    // R2
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !in_ready);

    // R2
    ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> in_ready);

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == acc_sr[4]);

    // R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R4
    zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && zero_sr[4]) |-> (out_i == '0 && out_q == '0));
endmodule

bind tdm_quad_mixer qmix_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
);

// File: tb/sim_tdm_quad_mixer.sv
`timescale 1ns/1ps
module sim_tdm_quad_mixer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready, out_valid;
    logic signed [15:0] in_sample = '0, in_cos = '0, in_sin = '0;
    logic signed [15:0] out_i, out_q;

    int checks = 0, failures = 0;
    int cyc = 0;
    bit done = 0;
    bit prev_acc = 0;
    string cur_tag = "R4";

    int exp_cyc [1024];
    logic signed [15:0] exp_i [1024], exp_q [1024];
    string exp_tag [1024];
    int wr = 0, rd = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tdm_quad_mixer u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sample(in_sample), .in_cos(in_cos), .in_sin(in_sin),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    function automatic logic signed [15:0] ref_mix(int s, int c);
        longint p, q;
        p = longint'(s) * longint'(c);
        q = (p + 64'sd16384) >>> 15;
        if (q > 32767) q = 32767;
        if (q < -32768) q = -32768;
        return 16'(q);
    endfunction

    function automatic int pick(int k);
        case (k)
            0: return -32768;  1: return -32767;  2: return -16384;
            3: return -12345;  4: return -1;      5: return 0;
            6: return 1;       7: return 3;       8: return 16384;
            9: return 20001;   10: return 32766;  default: return 32767;
        endcase
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // monitor: samples away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (prev_acc) chk(in_ready == 1'b0, "R2 ready low after accept", in_ready, 0);
            else          chk(in_ready == 1'b1, "R2 ready high when idle", in_ready, 1);
            if (out_valid) begin
                if (rd == wr) chk(1'b0, "R3 pulse without accepted sample", 1, 0);
                else begin
                    chk(cyc == exp_cyc[rd], "R3 latency", cyc, exp_cyc[rd]);
                    chk(out_i == exp_i[rd], {exp_tag[rd], " I (R4)"}, out_i, exp_i[rd]);
                    chk(out_q == exp_q[rd], {exp_tag[rd], " Q (R5)"}, out_q, exp_q[rd]);
                    rd++;
                end
            end else if (rd != wr && cyc >= exp_cyc[rd]) begin
                chk(1'b0, "R3 missing pulse", 0, 1);
                rd++;
            end
            prev_acc = in_valid && in_ready;
            if (in_valid && in_ready) begin
                exp_cyc[wr] = cyc + 5;
                exp_i[wr]   = ref_mix(in_sample, in_cos);
                exp_q[wr]   = ref_mix(in_sample, in_sin);
                exp_tag[wr] = cur_tag;
                wr++;
            end
        end
    end

    task automatic step(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic send(int s, int c, int n);
        bit got;
        in_valid = 1'b1; in_sample = 16'(s); in_cos = 16'(c); in_sin = 16'(n);
        do begin
            @(negedge clk); got = in_ready;
            @(posedge clk); #1;
        end while (!got);
        in_valid = 1'b0;
    endtask

    // drive junk during the refused cycle (R9)
    task automatic garble();
        in_valid = 1'b1; in_sample = 16'sd12121; in_cos = -16'sd777; in_sin = 16'sd31000;
        step(1);
        in_valid = 1'b0;
    endtask

    initial begin
        #1;
        // R1: values while in reset
        chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        chk(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
        step(3);
        rst_n = 1'b1;
        step(1);
        chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        chk(out_i == 0 && out_q == 0, "R1 outputs zero after reset", out_i, 0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

        // sweep: odd rows back to back (R8), even rows with idle gaps
        cur_tag = "R8 sweep";
        for (int a = 0; a < 12; a++) begin
            for (int b = 0; b < 12; b++) begin
                send(pick(a), pick(b), pick((b + 5) % 12));
                if (a % 2 == 0) step(b % 3);
            end
        end
        step(8);

        // R6: round half up around the half-LSB point
        cur_tag = "R6 rounding";
        for (int k = -8; k <= 8; k++) send(16384, k, -k);
        step(8);

        // R7: saturation on each carrier
        cur_tag = "R7 saturation";
        send(-32768, -32768, 0);
        send(-32768, 0, -32768);
        send(-32768, -32768, -32768);
        step(8);

        // R9: junk in the refused cycle must not disturb the sample in flight
        cur_tag = "R9 ignored input";
        for (int k = 0; k < 6; k++) begin
            send(pick(k + 3), pick(11 - k), pick(k));
            garble();
            step(1);
        end
        step(10);

        chk(rd == wr, "R3 one pulse per accepted sample", rd, wr);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5ns * 100000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule